// File: doc/BRIEF.md
# Cascaded H-Bridge Pulse Rotator

This block sits between the carrier comparator of one inverter phase and the gate drivers of a series chain of H-bridges. The comparator yields a single pulse train plus a sign bit. The rotator hands each new pulse to the next bridge in a fixed circular order. While a pulse is high, its bridge drives the diagonal chosen by the sign bit. Every other bridge sits in the zero state. The phase voltage is the sum of all bridge outputs, so the waveform is unchanged. Each bridge, however, switches at only 1/N of the phase pulse rate.

The number of bridges in use is set by a configuration input, up to a parameter maximum (default five). A half-cycle strobe from the reference generator marks the end of each half cycle of the fundamental. At that point the block checks whether the pulse count of the half cycle just ended is a non-zero multiple of the bridge count. In that case every bridge would see the same pulse position each half cycle, and the bridge sources would be loaded unevenly. A flag reports this.

Top module: `hbrot_rotator`

## Requirements
- R1: While `rst_n` is low at a clock edge, all gate outputs and `uneven_load` go to 0 and the rotation pointer returns to bridge 0. The first pulse after reset goes to bridge 0.
- R2: Gate outputs lag `pwm_in` by exactly one clock. Some bridge is active in a cycle if and only if `pwm_in` was 1 at the previous clock edge.
- R3: Successive pulses go to bridges 0, 1, …, N-1, 0, … where N is the effective bridge count. Over a whole number of rotations, every bridge receives the same number of pulses.
- R4: `pwm_neg` is sampled at the clock edge where a pulse starts. A value of 0 drives `gate_pos[k]` of the owning bridge k (positive diagonal). A value of 1 drives `gate_neg[k]` (negative diagonal). Changes of `pwm_neg` during the pulse are ignored.
- R5: At most one bridge is active at any time. A bridge never has `gate_pos` and `gate_neg` both high, and bridges that do not own the pulse output 00 (the zero state).
- R6: A pulse stays on the bridge that started it until `pwm_in` falls, whatever happens to the pointer.
- R7: A `cfg_bridges` value of 0, or a value above MAX_BRIDGES, is treated as MAX_BRIDGES.
- R8: At a clock edge where `half_strobe` is 1, `uneven_load` takes the value (P > 0 and P mod N == 0). P is the number of pulse starts since the previous strobe, including a start at that same edge. At all other edges `uneven_load` holds its value.
- R9: The half-cycle strobe does not move the rotation pointer. Rotation continues across half cycles.
- R10: If the bridge count is lowered to a value at or below the current pointer, the next pulse goes to bridge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_in | input | 1 | Pulse train from the carrier comparator |
| pwm_neg | input | 1 | Pulse sign: 0 positive, 1 negative |
| half_strobe | input | 1 | One-cycle strobe at the end of each fundamental half cycle |
| cfg_bridges | input | CW ($clog2(MAX_BRIDGES+1)) | Number of bridges in rotation |
| gate_pos | output | MAX_BRIDGES | Per-bridge positive-diagonal command |
| gate_neg | output | MAX_BRIDGES | Per-bridge negative-diagonal command |
| uneven_load | output | 1 | Last half cycle had a pulse count that is a multiple of the bridge count |

## Verification
The assertions assume that `pwm_in` is a clean synchronous level. Any low period therefore lasts at least one clock, which makes two active cycles in a row belong to the same pulse. They also assume that `cfg_bridges` changes only between pulses. The stimulus drives every input on the falling clock edge. Random pulse and gap widths are at least one cycle. The bridge count is changed only while `pwm_in` is low, right after a strobe, so the pulse count of a half cycle always refers to a single bridge count.

// File: rtl/hbrot_pkg.sv
// Shared types of the pulse rotator: the three bridge output states.
package hbrot_pkg;
    typedef enum logic [1:0] {
        BR_ZERO = 2'b00,  // both diagonals off, bridge contributes 0 V
        BR_POS  = 2'b01,  // positive diagonal conducts
        BR_NEG  = 2'b10   // negative diagonal conducts
    } br_state_e;
endpackage

// File: rtl/hbrot_edge.sv
// Rising-edge detector for the incoming pulse train.
// Assumes pwm_in is already synchronous to clk.
module hbrot_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    // Hold the previous sample of the pulse input.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/hbrot_modcnt.sv
// Modulo counter with a run-time limit. A stored value at or above the
// limit reads as 0, so lowering the limit never leaves an out-of-range value.
// Assumes limit >= 1 (the top clamps it).
module hbrot_modcnt #(
    parameter int IW = 3,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [CW-1:0] limit,
    output logic [IW-1:0] cur,
    output logic [IW-1:0] cur_plus
);
    logic [IW-1:0] cnt;
    logic [CW-1:0] cur_ext;

    // Fold an out-of-range stored value back to 0 and form the successor.
    always_comb begin
        cur      = (CW'(cnt) >= limit) ? '0 : cnt;
        cur_ext  = CW'(cur) + CW'(1);
        cur_plus = (cur_ext >= limit) ? '0 : IW'(cur_ext);
    end

    // Clear has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (adv) cnt <= cur_plus;
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R8

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (CW'(cnt) < $past(limit))); // R3
endmodule

// File: rtl/hbrot_decode.sv
// Turns the owning bridge index, activity and sign into per-bridge gate pairs.
// Assumes owner < NB whenever active is 1.
module hbrot_decode
    import hbrot_pkg::*;
#(
    parameter int NB = 5,
    parameter int IW = 3
) (
    input  logic          active,
    input  logic          neg,
    input  logic [IW-1:0] owner,
    output logic [NB-1:0] gate_pos,
    output logic [NB-1:0] gate_neg
);
    for (genvar i = 0; i < NB; i++) begin : g_br
        br_state_e st;
        // Pick the state for bridge i: zero unless it owns the live pulse.
        always_comb begin
            if (active && (owner == IW'(i))) st = neg ? BR_NEG : BR_POS;
            else                             st = BR_ZERO;
        end
        assign gate_pos[i] = (st == BR_POS);
        assign gate_neg[i] = (st == BR_NEG);
    end
endmodule

// File: rtl/hbrot_rotator.sv
// Pulse rotator for one phase of a cascaded H-bridge chain. Each pulse
// start is handed to the next bridge in a circular order, and the sign is
// latched for the whole pulse. At each half-cycle strobe the block flags
// a pulse count that is a non-zero multiple of the bridge count.
// Assumes pwm_in, pwm_neg and half_strobe are synchronous to clk, and
// cfg_bridges changes only while pwm_in is low.
module hbrot_rotator #(
    parameter int MAX_BRIDGES = 5,
    localparam int CW = $clog2(MAX_BRIDGES + 1),
    localparam int IW = (MAX_BRIDGES > 1) ? $clog2(MAX_BRIDGES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwm_in,
    input  logic                   pwm_neg,
    input  logic                   half_strobe,
    input  logic [CW-1:0]          cfg_bridges,
    output logic [MAX_BRIDGES-1:0] gate_pos,
    output logic [MAX_BRIDGES-1:0] gate_neg,
    output logic                   uneven_load
);
    logic          rise;
    logic [CW-1:0] n_eff;
    logic [IW-1:0] ptr_cur, ptr_plus, res_cur, res_plus;
    logic          active_q, neg_q, any_q, up_q;
    logic [IW-1:0] owner_q;

    // Clamp the configured bridge count into 1..MAX_BRIDGES.
    always_comb begin
        if (cfg_bridges == '0 || cfg_bridges > CW'(MAX_BRIDGES)) n_eff = CW'(MAX_BRIDGES);
        else                                                     n_eff = cfg_bridges;
    end

    hbrot_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(pwm_in), .rise(rise)
    );

    // Rotation pointer: never cleared by the strobe.
    hbrot_modcnt #(.IW(IW), .CW(CW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .adv(rise), .limit(n_eff),
        .cur(ptr_cur), .cur_plus(ptr_plus)
    );

    // Pulse count of the current half cycle, kept modulo the bridge count.
    hbrot_modcnt #(.IW(IW), .CW(CW)) u_res (
        .clk(clk), .rst_n(rst_n), .clr(half_strobe), .adv(rise), .limit(n_eff),
        .cur(res_cur), .cur_plus(res_plus)
    );

    // Capture owner and sign at a pulse start; drop the pulse when input falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            neg_q    <= 1'b0;
            owner_q  <= '0;
        end else if (rise) begin
            active_q <= 1'b1;
            neg_q    <= pwm_neg;
            owner_q  <= ptr_cur;
        end else if (!pwm_in) begin
            active_q <= 1'b0;
        end
    end

    // Note whether any pulse started in the current half cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           any_q <= 1'b0;
        else if (half_strobe) any_q <= 1'b0;
        else if (rise)        any_q <= 1'b1;
    end

    // Evaluate the even-loading rule at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            uneven_load <= 1'b0;
        else if (half_strobe)
            uneven_load <= (any_q || rise) && ((rise ? res_plus : res_cur) == '0);
    end

    // Marks cycles whose previous edge was out of reset.
    always_ff @(posedge clk) begin
        up_q <= rst_n;
    end

    hbrot_decode #(.NB(MAX_BRIDGES), .IW(IW)) u_dec (
        .active(active_q), .neg(neg_q), .owner(owner_q),
        .gate_pos(gate_pos), .gate_neg(gate_neg)
    );

    AST_ONE_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_pos | gate_neg) && ((gate_pos & gate_neg) == '0)); // R5

    AST_ONE_CYCLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> ((|(gate_pos | gate_neg)) == $past(pwm_in))); // R2

    AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && (|(gate_pos | gate_neg)) && $past(|(gate_pos | gate_neg)))
        |-> ($stable(gate_pos) && $stable(gate_neg))); // R6

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !$past(half_strobe)) |-> $stable(uneven_load)); // R8
endmodule

// File: tb/tb_hbrot_rotator.sv
module tb_hbrot_rotator;
    localparam int NB = 5;
    localparam int CW = $clog2(NB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0, pwm_neg = 1'b0, half_strobe = 1'b0;
    logic [CW-1:0] cfg_bridges = CW'(NB);
    logic [NB-1:0] gate_pos, gate_neg;
    logic uneven_load;

    int n_checks = 0, n_fail = 0;
    // Reference model state
    int  m_ptr = 0, m_own = 0, m_cnt = 0;
    bit  m_act = 0, m_neg = 0, m_flag = 0, m_prev = 0;
    int  br_cnt [NB];
    logic [NB-1:0] prev_act = '0;

    always #5 clk = ~clk;

    hbrot_rotator #(.MAX_BRIDGES(NB)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pwm_neg(pwm_neg),
        .half_strobe(half_strobe), .cfg_bridges(cfg_bridges),
        .gate_pos(gate_pos), .gate_neg(gate_neg), .uneven_load(uneven_load)
    );

    function automatic int eff_n(input logic [CW-1:0] c);
        return (c == 0 || c > NB) ? NB : int'(c);
    endfunction

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model after posedge, compare.
    task automatic step(input bit p, input bit ng, input bit st, input string tag);
        logic [NB-1:0] ep, en;
        int n;
        @(negedge clk);
        pwm_in = p; pwm_neg = ng; half_strobe = st;
        @(posedge clk);
        #1;
        n = eff_n(cfg_bridges);
        if (!rst_n) begin
            m_ptr = 0; m_act = 0; m_flag = 0; m_cnt = 0; m_prev = 0;
        end else begin
            if (p && !m_prev) begin
                m_own = (m_ptr >= n) ? 0 : m_ptr;
                m_ptr = (m_own + 1 >= n) ? 0 : m_own + 1;
                m_neg = ng; m_act = 1; m_cnt++;
            end else if (!p) m_act = 0;
            if (st) begin
                m_flag = (m_cnt > 0) && (m_cnt % n == 0);
                m_cnt = 0;
            end
            m_prev = p;
        end
        ep = (m_act && !m_neg) ? NB'(1) << m_own : '0;
        en = (m_act &&  m_neg) ? NB'(1) << m_own : '0;
        chk(gate_pos == ep && gate_neg == en, tag,
            $sformatf("pos=%b neg=%b", gate_pos, gate_neg),
            $sformatf("pos=%b neg=%b", ep, en));
        chk(uneven_load == m_flag, {tag, " R8 flag"},
            $sformatf("%0b", uneven_load), $sformatf("%0b", m_flag));
        chk($countones(gate_pos | gate_neg) <= 1 && (gate_pos & gate_neg) == 0,
            "R5 one bridge", $sformatf("%b/%b", gate_pos, gate_neg), "onehot0");
        for (int i = 0; i < NB; i++)
            if ((gate_pos[i] | gate_neg[i]) && !prev_act[i]) br_cnt[i]++;
        prev_act = gate_pos | gate_neg;
    endtask

    task automatic pulse(input int w, input bit ng, input int gap, input string tag);
        for (int i = 0; i < w; i++) step(1'b1, ng, 1'b0, tag);
        for (int i = 0; i < gap; i++) step(1'b0, ng, 1'b0, tag);
    endtask

    task automatic clear_br_cnt();
        for (int i = 0; i < NB; i++) br_cnt[i] = 0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7117));
        clear_br_cnt();
        // R1: reset with active inputs
        rst_n = 1'b0;
        step(1'b1, 1'b0, 1'b1, "R1 reset");
        step(1'b1, 1'b1, 1'b0, "R1 reset");
        @(negedge clk); rst_n = 1'b1; pwm_in = 1'b0;
        step(1'b0, 1'b0, 1'b0, "R1 idle after reset");
        // R1/R2/R3: first pulse on bridge 0, then round robin
        pulse(3, 1'b0, 2, "R1 first pulse bridge0 R2");
        pulse(2, 1'b1, 1, "R3 second pulse R4 neg");
        // R4: sign change during pulse ignored
        step(1'b1, 1'b0, 1'b0, "R4 latch sign");
        step(1'b1, 1'b1, 1'b0, "R4 sign change ignored");
        step(1'b1, 1'b1, 1'b0, "R6 hold owner");
        step(1'b0, 1'b1, 1'b0, "R2 fall");
        pulse(1, 1'b0, 1, "R3 rotation");
        pulse(1, 1'b1, 1, "R3 rotation");
        pulse(1, 1'b0, 1, "R3 wrap to bridge0");
        // R9: strobe does not move the pointer; 6 pulses, 6 mod 5 != 0
        step(1'b0, 1'b0, 1'b1, "R9 strobe");
        // R8: exactly 5 pulses in a half cycle, last one on strobe edge
        pulse(1, 1'b0, 1, "R8 count"); pulse(1, 1'b0, 1, "R8 count");
        pulse(1, 1'b0, 1, "R8 count"); pulse(1, 1'b0, 1, "R8 count");
        step(1'b1, 1'b0, 1'b1, "R8 multiple flagged");
        step(1'b0, 1'b0, 1'b0, "R8 hold");
        // R8: empty half cycle is not flagged
        step(1'b0, 1'b0, 1'b1, "R8 zero pulses");
        // R7: cfg 0 and cfg 7 act as 5
        cfg_bridges = '0;
        for (int k = 0; k < 6; k++) pulse(1, 1'b0, 1, "R7 cfg zero");
        cfg_bridges = CW'(7);
        for (int k = 0; k < 6; k++) pulse(1, 1'b1, 1, "R7 cfg high");
        step(1'b0, 1'b0, 1'b1, "R7 strobe");
        // R10: lower count below pointer
        cfg_bridges = CW'(5);
        while (m_ptr != 4) pulse(1, 1'b0, 1, "R10 setup");
        step(1'b0, 1'b0, 1'b1, "R10 strobe");
        cfg_bridges = CW'(3);
        pulse(2, 1'b0, 1, "R10 goes to bridge0");
        pulse(1, 1'b0, 1, "R10 next");
        pulse(1, 1'b0, 1, "R8 three of three");
        step(1'b0, 1'b0, 1'b1, "R8 flagged for three");
        // R3 even loading: 5 bridges, 3 pulses per half cycle, 5 half cycles
        cfg_bridges = CW'(5);
        while (m_ptr != 0) pulse(1, 1'b0, 1, "R3 align");
        step(1'b0, 1'b0, 1'b1, "R3 strobe");
        clear_br_cnt();
        for (int h = 0; h < 5; h++) begin
            for (int k = 0; k < 3; k++) pulse(1 + k, h[0], 2, "R3 load");
            step(1'b0, 1'b0, 1'b1, "R3 load strobe");
        end
        for (int i = 0; i < NB; i++)
            chk(br_cnt[i] == 3, "R3 equal loading",
                $sformatf("bridge%0d=%0d", i, br_cnt[i]), "3");
        // Random phase
        for (int r = 0; r < 400; r++) begin
            int w, g;
            w = 1 + int'($urandom_range(3));
            g = 1 + int'($urandom_range(3));
            pulse(w, 1'($urandom_range(1)), g, "R3 R4 random");
            if ($urandom_range(3) == 0) step(1'b0, 1'b0, 1'b1, "R8 random strobe");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule